// File: doc/BRIEF.md
# Demultiplexed Parallel Slave Port

This block lets an external host reach a word-organised internal buffer over a parallel bus that has separate address and data lines. The host supplies a 14-bit word address, a 16-bit data bus (split on chip into an input, an output and an output enable), and four active-high controls: a select, a read strobe, and a write strobe for each byte lane. None of these controls is assumed to be synchronous to the block clock. Each one passes through a two-flop synchronizer and is then edge-detected.

A read starts on the synchronized rising edge of the read strobe. The port drives a fixed filler word for a programmable number of cycles, which stands in for the undefined bus contents during the access time. After that it drives the full 16-bit word held at the address. A write commits on the synchronized falling edge of a byte strobe. The address and data are taken from the bus at that moment, so the host keeps them steady for a few cycles after it drops the strobe. A read strobe raised together with a write strobe while the port is selected is an illegal access. The block reports it on an error output and does not act on it.

Top module: `pport_slave`

## Requirements
- R1: While reset is held, and after it is released, the output enable and the error output are low and the data output is zero. Reset clears every buffer word to zero.
- R2: A read returns the complete 16-bit word stored at the address, whatever byte the host intends to use.
- R3: The output enable is high only after a read strobe that was synchronized while the select was high. A read made with the select low never drives the bus.
- R4: The output enable rises on the third clock edge after the raw read strobe rises. For the next LAT cycles (default 3) the data output holds the filler word FILL (default 16'hDEAD). The stored word is driven from the edge after that.
- R5: A pulse on the low-lane write strobe (wr_lo_i) writes data_i[7:0] into bits 7:0 of the addressed word and leaves bits 15:8 unchanged.
- R6: A pulse on the high-lane write strobe (wr_hi_i) writes data_i[15:8] into bits 15:8 of the addressed word and leaves bits 7:0 unchanged.
- R7: Pulsing both write strobes together writes all 16 bits in one access.
- R8: With the select tied high, every access works. A write pulsed while the select is low leaves the buffer unchanged.
- R9: A read strobe held high together with either write strobe while selected is illegal. The error output goes high on the third edge after the raw strobes overlap, the bus is not driven, and the write is discarded.
- R10: The output enable falls on the clock edge that follows the synchronized fall of the read strobe. That is the third edge after the raw strobe falls.
- R11: Only the low DEPTH_LOG2 address bits (default 8) select a word. Addresses that differ only in the upper bits alias to the same word.
- R12: A write uses the address and data present on the third clock edge after the raw strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Port select, active high (may be tied high) |
| rd_i | input | 1 | Read strobe, active high |
| wr_lo_i | input | 1 | Low-byte write strobe, active high |
| wr_hi_i | input | 1 | High-byte write strobe, active high |
| addr_i | input | ADDR_W (14) | Word address |
| data_i | input | DATA_W (16) | Data bus, input half |
| data_o | output | DATA_W (16) | Data bus, output half |
| data_oe_o | output | 1 | Drive enable for the data bus |
| err_o | output | 1 | Illegal read/write overlap |

## Verification
Every strobe change costs two synchronizer edges plus one state edge. The output enable, the first filler word and the error flag are therefore due on the third edge after the stimulus, the stored word LAT edges later, and a write lands on the third edge after its strobe falls. The bench changes inputs on falling clock edges and counts rising edges to the exact one where each result is due. It samples on the following falling edge, and it also checks the edge before to confirm that the result has not appeared early. The host's address and data are held for four cycles after a write strobe drops, so they are still steady when the commit edge samples them.

// File: rtl/pps_pkg.sv
package pps_pkg;

    // Host control lines after synchronization; field order matches the
    // bundle built at the top level.
    typedef struct packed {
        logic cs;
        logic rd;
        logic wrh;
        logic wrl;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/pps_ram.sv
module pps_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW/8-1:0]   we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DW-1:0]     rdata_o
);

    localparam int DEPTH = 1 << AW;
    localparam int LANES = DW / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) lane_mem[k] <= '0;
            end else if (we_i[l]) begin
                lane_mem[waddr_i] <= wdata_i[8*l +: 8];
            end
        end

        assign rdata_o[8*l +: 8] = lane_mem[raddr_i];
    end

endmodule

// File: rtl/pport_slave.sv
module pport_slave
    import pps_pkg::*;
#(
    parameter int              ADDR_W     = 14,
    parameter int              DATA_W     = 16,
    parameter int              DEPTH_LOG2 = 8,
    parameter int              LAT        = 3,
    parameter int              SYNC_STG   = 2,
    parameter logic [DATA_W-1:0] FILL     = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              rd_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              err_o
);

    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        strobe_t                 prev;
        logic                    oe;
        logic [CNT_W-1:0]        cnt;
        logic [DEPTH_LOG2-1:0]   raddr;
        logic [DATA_W-1:0]       dout;
        logic                    err;
        logic                    bad;
    } state_t;

    state_t st_d, st_q;

    logic [STROBE_W-1:0] raw_bits, sync_bits;
    strobe_t             s;
    logic [LANES-1:0]    we;
    logic [DATA_W-1:0]   ram_rdata;
    logic                illegal, rd_ok, rd_rise, commit_ok;

    assign raw_bits = {sel_i, rd_i, wr_hi_i, wr_lo_i};

    pps_sync #(
        .W      (STROBE_W),
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bits),
        .sync_o  (sync_bits)
    );

    assign s = strobe_t'(sync_bits);

    pps_ram #(
        .AW (DEPTH_LOG2),
        .DW (DATA_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (addr_i[DEPTH_LOG2-1:0]),
        .wdata_i (data_i),
        .raddr_i (st_q.raddr),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = s;

        illegal   = s.cs & s.rd & (s.wrl | s.wrh);
        rd_ok     = s.cs & s.rd & ~s.wrl & ~s.wrh;
        rd_rise   = s.rd & ~st_q.prev.rd;

        st_d.err  = illegal;
        // stays set until every strobe has gone low again
        st_d.bad  = (st_q.bad | illegal) & (s.rd | s.wrl | s.wrh);

        // write commit on synchronized falling edge of each lane strobe
        commit_ok = s.cs & ~st_q.bad;
        we        = '0;
        we[0]     = ~s.wrl & st_q.prev.wrl & commit_ok;
        if (LANES > 1) begin
            we[LANES-1] = ~s.wrh & st_q.prev.wrh & commit_ok;
        end

        // read path
        if (!rd_ok) begin
            st_d.oe   = 1'b0;
            st_d.cnt  = '0;
            st_d.dout = '0;
        end else if (rd_rise) begin
            st_d.oe    = 1'b1;
            st_d.cnt   = CNT_W'(LAT - 1);
            st_d.raddr = addr_i[DEPTH_LOG2-1:0];
            st_d.dout  = FILL;
        end else if (st_q.oe) begin
            if (st_q.cnt != '0) begin
                st_d.cnt  = st_q.cnt - 1'b1;
                st_d.dout = FILL;
            end else begin
                st_d.dout = ram_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o    = st_q.dout;
    assign data_oe_o = st_q.oe;
    assign err_o     = st_q.err;

endmodule

// File: rtl/pps_checker.sv
module pps_checker
    import pps_pkg::*;
#(
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] FILL   = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           sync_s,
    input  logic [DATA_W-1:0] data_o,
    input  logic              data_oe_o,
    input  logic              err_o
);

    // R3: bus driven only after a selected, synchronized read strobe
    a_r3_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> $past(sync_s.cs && sync_s.rd));

    // R4: the first driven word is always the filler
    a_r4_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> (data_o == FILL));

    // R9: an illegal overlap never drives the bus
    a_r9_err_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !data_oe_o);

    // R10: enable drops one edge after the synchronized strobe falls
    a_r10_oe_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_s.rd) |=> !data_oe_o);

    // R1: undriven bus carries zero
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> (data_o == '0));

endmodule

bind pport_slave pps_checker #(
    .DATA_W (DATA_W),
    .FILL   (FILL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_s    (s),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .err_o     (err_o)
);

// File: tb/pport_slave_test.sv
`timescale 1ns/1ps
module pport_slave_test;

    localparam int          LAT  = 3;
    localparam logic [15:0] FILL = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0, rd_i = 1'b0, wr_lo_i = 1'b0, wr_hi_i = 1'b0;
    logic [13:0] addr_i = '0;
    logic [15:0] data_i = '0;
    logic [15:0] data_o;
    logic        data_oe_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pport_slave #(.LAT(LAT), .FILL(FILL)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rd_i(rd_i),
        .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .addr_i(addr_i),
        .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [1:0]  mask;   // bit1 = high lane, bit0 = low lane
        logic [13:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'b11, 14'h0005, 16'h1234, 16'h1234},   // R7 full word
        '{2'b01, 14'h0005, 16'hABCD, 16'h12CD},   // R5 low lane
        '{2'b10, 14'h0005, 16'h5678, 16'h56CD},   // R6 high lane
        '{2'b11, 14'h3FFF, 16'hBEEF, 16'hBEEF},   // R7 top address
        '{2'b01, 14'h00FF, 16'h0011, 16'hBE11},   // R11 alias of 3FFF
        '{2'b11, 14'h0000, 16'h0001, 16'h0001}    // R2 word 0
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [13:0] a, input logic [15:0] d,
                            input logic [1:0] m, input logic cs);
        @(negedge clk);
        sel_i = cs; addr_i = a; data_i = d;
        wr_lo_i = m[0]; wr_hi_i = m[1];
        cyc(4);
        wr_lo_i = 1'b0; wr_hi_i = 1'b0;
        cyc(4);              // hold address/data past commit edge (R12)
        sel_i = 1'b1;
    endtask

    task automatic do_read(input logic [13:0] a, output logic [15:0] got);
        @(negedge clk);
        sel_i = 1'b1; addr_i = a; rd_i = 1'b1;
        cyc(LAT + 3);
        got = data_o;
        rd_i = 1'b0;
        cyc(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [15:0] got;

        // R1: reset state
        cyc(3);
        chk("R1 oe in reset", {15'd0, data_oe_o}, 16'd0);
        chk("R1 err in reset", {15'd0, err_o}, 16'd0);
        rst_n = 1'b1;
        sel_i = 1'b1;          // R8: select tied high from here on
        cyc(2);
        chk("R1 data after reset", data_o, 16'h0000);
        do_read(14'h0042, got);
        chk("R1 cleared word", got, 16'h0000);

        // table walk: write then read back
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].addr, VECS[i].wdata, VECS[i].mask, 1'b1);
            do_read(VECS[i].addr, got);
            chk($sformatf("R2/R5/R6/R7/R8/R11 vector %0d", i), got, VECS[i].exp);
        end

        // R4 / R10: exact read timing on word 5 (holds 56CD)
        @(negedge clk);
        addr_i = 14'h0005; rd_i = 1'b1;
        cyc(2);
        chk("R4 oe not early", {15'd0, data_oe_o}, 16'd0);
        cyc(1);
        chk("R4 oe on third edge", {15'd0, data_oe_o}, 16'd1);
        chk("R4 filler first", data_o, FILL);
        for (int k = 1; k < LAT; k++) begin
            cyc(1);
            chk("R4 filler held", data_o, FILL);
        end
        cyc(1);
        chk("R4 data after latency", data_o, 16'h56CD);
        rd_i = 1'b0;
        cyc(2);
        chk("R10 oe still high two edges", {15'd0, data_oe_o}, 16'd1);
        cyc(1);
        chk("R10 oe low third edge", {15'd0, data_oe_o}, 16'd0);

        // R3: read with select low does not drive
        @(negedge clk);
        sel_i = 1'b0; rd_i = 1'b1; addr_i = 14'h0005;
        cyc(LAT + 5);
        chk("R3 no drive unselected", {15'd0, data_oe_o}, 16'd0);
        rd_i = 1'b0;
        cyc(4);
        sel_i = 1'b1;

        // R8: write with select low ignored
        do_write(14'h0005, 16'hFFFF, 2'b11, 1'b0);
        do_read(14'h0005, got);
        chk("R8 unselected write ignored", got, 16'h56CD);

        // R9: illegal overlap
        @(negedge clk);
        sel_i = 1'b1; addr_i = 14'h0005; data_i = 16'h0F0F;
        rd_i = 1'b1; wr_lo_i = 1'b1;
        cyc(2);
        chk("R9 err not early", {15'd0, err_o}, 16'd0);
        cyc(1);
        chk("R9 err on third edge", {15'd0, err_o}, 16'd1);
        cyc(3);
        chk("R9 no drive", {15'd0, data_oe_o}, 16'd0);
        rd_i = 1'b0; wr_lo_i = 1'b0;
        cyc(5);
        chk("R9 err clears", {15'd0, err_o}, 16'd0);
        do_read(14'h0005, got);
        chk("R9 write discarded", got, 16'h56CD);

        // R12: address/data sampled at commit, not at strobe rise
        @(negedge clk);
        addr_i = 14'h0010; data_i = 16'h1111; wr_lo_i = 1'b1; wr_hi_i = 1'b1;
        cyc(4);
        addr_i = 14'h0011; data_i = 16'h2222;
        cyc(1);
        wr_lo_i = 1'b0; wr_hi_i = 1'b0;
        cyc(4);
        do_read(14'h0011, got);
        chk("R12 commit-time address/data", got, 16'h2222);
        do_read(14'h0010, got);
        chk("R12 strobe-rise address untouched", got, 16'h0000);

        report();
    end

endmodule